// File: doc/BRIEF.md
# Dual-Clock Mailbox Register Pair

This block gives two ports in unrelated clock domains a side channel for short control words that bypasses the data queue. Port A and port B each own one outbound mail register. A port that is selected, enabled and set to write, with its mailbox-select input high, loads its data into its outbound register. The same port set to read, with mailbox-select high, sees the register the other side fills. With mailbox-select low, a port's read data comes from the queue output word that the surrounding design supplies.

Each mail register has an active-low full flag (high = empty) that is visible in both clock domains. A write drops the flag in the writer's domain at once. A message stays protected until the receiver reads it. The receiver's read raises the flag in its own view at once and in the writer's view after the event crosses back. A read never alters the stored word.

Top module: `mbox_pair`

## Requirements
- R1: While reset is low and after it is released, all four flag outputs are 1 and both mail registers hold zero, so a read with mailbox-select high returns 0 on either port.
- R2: A port A access with cs, en, wr (1 = write) and mbx all 1, made while the port A view of flag 1 is 1, stores wdata_a_i into mail register 1 on that clock A edge and drives mail1_flag_a_o to 0 right after it.
- R3: The same access on port B stores wdata_b_i into mail register 2 on that clock B edge and drives mail2_flag_b_o to 0 right after it.
- R4: A write with any of cs, en or mbx at 0 leaves the mail register and both its flag outputs unchanged.
- R5: A mailbox write while the writer's view of that register's flag is 0 is ignored: the content and the flags stay as they were.
- R6: A receiver read with mbx 1, while the receiver's view of the flag is 0, sets that view to 1 right after the read edge. It sets the writer's view to 1 on the second writer-clock rising edge after the read edge, and not on the first.
- R7: After an accepted write, the receiver's view of the flag stays 1 after the first receiver-clock rising edge and is 0 after the second.
- R8: rdata_a_o equals mail register 2 when mbx_a_i is 1 and fifo_q_a_i when it is 0. rdata_b_o equals mail register 1 when mbx_b_i is 1 and fifo_q_b_i when it is 0.
- R9: Reading a mail register leaves its content unchanged. A second read returns the same word.
- R10: A receiver read made while the receiver's view shows empty (flag 1) has no later effect: a message written after it stays flagged unread in both views.
- R11: A mailbox write that lands on the same writer edge at which a read acknowledgement completes is ignored. The flag ends high and the old content remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_a_i | input | 1 | Port A chip select |
| en_a_i | input | 1 | Port A enable |
| wr_a_i | input | 1 | Port A direction, 1 = write |
| mbx_a_i | input | 1 | Port A mailbox select |
| wdata_a_i | input | DW | Port A write data |
| fifo_q_a_i | input | DW | Queue output word for port A reads |
| rdata_a_o | output | DW | Port A read data |
| mail1_flag_a_o | output | 1 | Flag 1, clock A view, 0 = full |
| mail2_flag_a_o | output | 1 | Flag 2, clock A view, 0 = full |
| cs_b_i | input | 1 | Port B chip select |
| en_b_i | input | 1 | Port B enable |
| wr_b_i | input | 1 | Port B direction, 1 = write |
| mbx_b_i | input | 1 | Port B mailbox select |
| wdata_b_i | input | DW | Port B write data |
| fifo_q_b_i | input | DW | Queue output word for port B reads |
| rdata_b_o | output | DW | Port B read data |
| mail1_flag_b_o | output | 1 | Flag 1, clock B view, 0 = full |
| mail2_flag_b_o | output | 1 | Flag 2, clock B view, 0 = full |

## Verification
The two events that can meet are a new write from the sender and the arrival of the receiver's acknowledgement in the sender's domain. The bench reads mail register 1 on port B, counts clock A edges, and places a port A mailbox write exactly on the second edge, where the acknowledgement completes. It expects the flag low after the first edge and high after the second, and then expects a later port B read to return the old word, which shows the colliding write was dropped.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned MAIL_W_DEF = 36;

  typedef struct packed {
    logic cs;
    logic en;
    logic wr;
    logic mbx;
  } port_ctl_t;

  function automatic logic mail_write(port_ctl_t c);
    return c.cs & c.en & c.wr & c.mbx;
  endfunction

  function automatic logic mail_read(port_ctl_t c);
    return c.cs & c.en & ~c.wr & c.mbx;
  endfunction
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;
  logic [N-1:0] sr_q;

  for (genvar s = 0; s < N; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q[s] <= 1'b0;
      else if (s == 0) sr_q[s] <= d_i;
      else sr_q[s] <= sr_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = sr_q[N-1];
endmodule

// File: rtl/mbox_channel.sv
// One direction: register and toggles live in the writer domain, ack toggle in the reader domain.
module mbox_channel #(
  parameter int unsigned DW          = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic          rd_req_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mail_o,
  output logic          wr_empty_o,
  output logic          rd_empty_o
);
  logic [DW-1:0] mail_q;
  logic wtog_q, rtog_q, wtog_s, rtog_s;

  assign wr_empty_o = (wtog_q == rtog_s);
  assign rd_empty_o = (wtog_s == rtog_q);
  assign mail_o     = mail_q;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mail_q <= '0;
      wtog_q <= 1'b0;
    end else if (wr_req_i && wr_empty_o) begin
      mail_q <= wdata_i;
      wtog_q <= ~wtog_q;
    end
  end

  // only a pending message can be acknowledged
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rtog_q <= 1'b0;
    else if (rd_req_i && !rd_empty_o) rtog_q <= ~rtog_q;
  end

  mbox_sync #(.STAGES(SYNC_STAGES)) i_sync_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wtog_q),
    .q_o   (wtog_s)
  );

  mbox_sync #(.STAGES(SYNC_STAGES)) i_sync_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rtog_q),
    .q_o   (rtog_s)
  );
endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
  import mbox_pkg::*;
#(
  parameter int unsigned DW          = MAIL_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          cs_a_i,
  input  logic          en_a_i,
  input  logic          wr_a_i,
  input  logic          mbx_a_i,
  input  logic [DW-1:0] wdata_a_i,
  input  logic [DW-1:0] fifo_q_a_i,
  output logic [DW-1:0] rdata_a_o,
  output logic          mail1_flag_a_o,
  output logic          mail2_flag_a_o,
  input  logic          cs_b_i,
  input  logic          en_b_i,
  input  logic          wr_b_i,
  input  logic          mbx_b_i,
  input  logic [DW-1:0] wdata_b_i,
  input  logic [DW-1:0] fifo_q_b_i,
  output logic [DW-1:0] rdata_b_o,
  output logic          mail1_flag_b_o,
  output logic          mail2_flag_b_o
);
  port_ctl_t ctl_a, ctl_b;
  logic [DW-1:0] mail1_q, mail2_q;

  assign ctl_a = '{cs: cs_a_i, en: en_a_i, wr: wr_a_i, mbx: mbx_a_i};
  assign ctl_b = '{cs: cs_b_i, en: en_b_i, wr: wr_b_i, mbx: mbx_b_i};

  mbox_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_ch_a2b (
    .wclk_i    (clk_a_i),
    .rclk_i    (clk_b_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (mail_write(ctl_a)),
    .rd_req_i  (mail_read(ctl_b)),
    .wdata_i   (wdata_a_i),
    .mail_o    (mail1_q),
    .wr_empty_o(mail1_flag_a_o),
    .rd_empty_o(mail1_flag_b_o)
  );

  mbox_channel #(.DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_ch_b2a (
    .wclk_i    (clk_b_i),
    .rclk_i    (clk_a_i),
    .rst_ni    (rst_ni),
    .wr_req_i  (mail_write(ctl_b)),
    .rd_req_i  (mail_read(ctl_a)),
    .wdata_i   (wdata_b_i),
    .mail_o    (mail2_q),
    .wr_empty_o(mail2_flag_b_o),
    .rd_empty_o(mail2_flag_a_o)
  );

  assign rdata_a_o = mbx_a_i ? mail2_q : fifo_q_a_i;
  assign rdata_b_o = mbx_b_i ? mail1_q : fifo_q_b_i;
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_a_i,
  input logic          clk_b_i,
  input logic          rst_ni,
  input logic          cs_a_i,
  input logic          en_a_i,
  input logic          wr_a_i,
  input logic          mbx_a_i,
  input logic [DW-1:0] wdata_a_i,
  input logic          cs_b_i,
  input logic          en_b_i,
  input logic          wr_b_i,
  input logic          mbx_b_i,
  input logic [DW-1:0] wdata_b_i,
  input logic [DW-1:0] mail1_q,
  input logic [DW-1:0] mail2_q,
  input logic          mail1_flag_a_o,
  input logic          mail2_flag_a_o,
  input logic          mail1_flag_b_o,
  input logic          mail2_flag_b_o
);
  logic wr_a, rd_a, wr_b, rd_b;
  assign wr_a = cs_a_i && en_a_i && wr_a_i && mbx_a_i;
  assign rd_a = cs_a_i && en_a_i && !wr_a_i && mbx_a_i;
  assign wr_b = cs_b_i && en_b_i && wr_b_i && mbx_b_i;
  assign rd_b = cs_b_i && en_b_i && !wr_b_i && mbx_b_i;

  AST_M1_WR_CLR: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (wr_a && mail1_flag_a_o) |=> !mail1_flag_a_o); // R2
  AST_M1_LOAD: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (wr_a && mail1_flag_a_o) |=> (mail1_q == $past(wdata_a_i))); // R2
  AST_M2_WR_CLR: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (wr_b && mail2_flag_b_o) |=> !mail2_flag_b_o); // R3
  AST_M1_HOLD: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !mail1_flag_a_o |=> $stable(mail1_q)); // R5
  AST_M2_HOLD: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !mail2_flag_b_o |=> $stable(mail2_q)); // R5
  AST_M1_ACK_RX: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (rd_b && !mail1_flag_b_o) |=> mail1_flag_b_o); // R6
  AST_M2_ACK_RX: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (rd_a && !mail2_flag_a_o) |=> mail2_flag_a_o); // R6
  AST_M1_RX_KEEP: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!mail1_flag_b_o && !rd_b) |=> !mail1_flag_b_o); // R10
  AST_M2_RX_KEEP: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!mail2_flag_a_o && !rd_a) |=> !mail2_flag_a_o); // R10
endmodule

bind mbox_pair mbox_pair_chk #(.DW(DW)) i_chk (
  .clk_a_i       (clk_a_i),
  .clk_b_i       (clk_b_i),
  .rst_ni        (rst_ni),
  .cs_a_i        (cs_a_i),
  .en_a_i        (en_a_i),
  .wr_a_i        (wr_a_i),
  .mbx_a_i       (mbx_a_i),
  .wdata_a_i     (wdata_a_i),
  .cs_b_i        (cs_b_i),
  .en_b_i        (en_b_i),
  .wr_b_i        (wr_b_i),
  .mbx_b_i       (mbx_b_i),
  .wdata_b_i     (wdata_b_i),
  .mail1_q       (mail1_q),
  .mail2_q       (mail2_q),
  .mail1_flag_a_o(mail1_flag_a_o),
  .mail2_flag_a_o(mail2_flag_a_o),
  .mail1_flag_b_o(mail1_flag_b_o),
  .mail2_flag_b_o(mail2_flag_b_o)
);

// File: tb/test_mbox_pair.sv
`timescale 1ns/100ps
module test_mbox_pair;
  localparam int DW = 36;
  localparam real PER_A = 10.0;
  localparam real PER_B = 14.0;
  localparam logic [DW-1:0] FQA = 36'hA_5A5A_5A5A;
  localparam logic [DW-1:0] FQB = 36'h0_F0F0_F0F0;
  localparam logic [DW-1:0] D1 = 36'h1_2345_6789, D2 = 36'hF_EDCB_A987;
  localparam logic [DW-1:0] D3 = 36'h3_3333_0000, D4 = 36'h4_4444_4444;
  localparam logic [DW-1:0] D5 = 36'h5_0505_0A0A, D6 = 36'h6_6600_0066;
  localparam logic [DW-1:0] D7 = 36'h7_7777_7777, D8 = 36'h8_0000_0008;

  typedef struct packed {
    logic          port;  // 0 = A, 1 = B
    logic          wr;
    logic          mbx;
    logic          cs;
    logic          en;
    logic [DW-1:0] data;
    logic [DW-1:0] exp;
    logic          f1;
    logic          f2;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, D1, '0,  1'b0, 1'b1, 4'd2},  // R2 load
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, D2, '0,  1'b0, 1'b1, 4'd5},  // R5 full
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, D1,  1'b1, 1'b1, 4'd6},  // R6 ack
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, D1,  1'b1, 1'b1, 4'd9},  // R9 reread
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, '0, FQB, 1'b1, 1'b1, 4'd8},  // R8 queue
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, D3, '0,  1'b1, 1'b0, 4'd3},  // R3 load
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, '0, D3,  1'b1, 1'b1, 4'd6},  // R6 ack
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, '0, FQA, 1'b1, 1'b1, 4'd8},  // R8 queue
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, D4, '0,  1'b1, 1'b1, 4'd4},  // R4 cs
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, D4, '0,  1'b1, 1'b1, 4'd4},  // R4 en
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, D4, '0,  1'b1, 1'b1, 4'd4},  // R4 mbx
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, D1,  1'b1, 1'b1, 4'd9},  // R9 unchanged
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, D5, '0,  1'b0, 1'b1, 4'd2},  // R2 again
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, '0, D5,  1'b1, 1'b1, 4'd6}   // R6 ack
  };

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic cs_a = 0, en_a = 0, wr_a = 0, mbx_a = 0;
  logic cs_b = 0, en_b = 0, wr_b = 0, mbx_b = 0;
  logic [DW-1:0] wd_a = '0, wd_b = '0;
  logic [DW-1:0] rd_a, rd_b;
  logic f1a, f2a, f1b, f2b;
  int n_chk = 0, n_bad = 0;

  always #(PER_A / 2) clk_a = ~clk_a;
  initial begin
    #0.3;
    forever #(PER_B / 2) clk_b = ~clk_b;
  end

  mbox_pair #(.DW(DW)) i_mbox_pair (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .cs_a_i(cs_a), .en_a_i(en_a), .wr_a_i(wr_a), .mbx_a_i(mbx_a),
    .wdata_a_i(wd_a), .fifo_q_a_i(FQA), .rdata_a_o(rd_a),
    .mail1_flag_a_o(f1a), .mail2_flag_a_o(f2a),
    .cs_b_i(cs_b), .en_b_i(en_b), .wr_b_i(wr_b), .mbx_b_i(mbx_b),
    .wdata_b_i(wd_b), .fifo_q_b_i(FQB), .rdata_b_o(rd_b),
    .mail1_flag_b_o(f1b), .mail2_flag_b_o(f2b)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic op(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("R%0d entry %0d", v.req, idx);
    if (!v.port) begin
      @(negedge clk_a);
      cs_a = v.cs; en_a = v.en; wr_a = v.wr; mbx_a = v.mbx; wd_a = v.data;
      #2;
      if (!v.wr) check(tag, rd_a, v.exp);
      @(posedge clk_a); #1;
      cs_a = 0; en_a = 0; wr_a = 0; mbx_a = 0;
    end else begin
      @(negedge clk_b);
      cs_b = v.cs; en_b = v.en; wr_b = v.wr; mbx_b = v.mbx; wd_b = v.data;
      #2;
      if (!v.wr) check(tag, rd_b, v.exp);
      @(posedge clk_b); #1;
      cs_b = 0; en_b = 0; wr_b = 0; mbx_b = 0;
    end
    repeat (6) @(posedge clk_b);
    #1;
    check(tag, {35'd0, f1a}, {35'd0, v.f1});
    check(tag, {35'd0, f1b}, {35'd0, v.f1});
    check(tag, {35'd0, f2a}, {35'd0, v.f2});
    check(tag, {35'd0, f2b}, {35'd0, v.f2});
  endtask

  task automatic read_b_mail(input string req, input logic [DW-1:0] exp);
    @(negedge clk_b);
    cs_b = 1; en_b = 1; wr_b = 0; mbx_b = 1;
    #2 check(req, rd_b, exp);
    @(posedge clk_b); #1;
    cs_b = 0; en_b = 0; mbx_b = 0;
  endtask

  task automatic write_a_mail(input logic [DW-1:0] d);
    @(negedge clk_a);
    cs_a = 1; en_a = 1; wr_a = 1; mbx_a = 1; wd_a = d;
    @(posedge clk_a); #1;
    cs_a = 0; en_a = 0; wr_a = 0; mbx_a = 0;
  endtask

  initial begin
    #(PER_A * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk_a);
    #1;
    check("R1 flags in reset", {32'd0, f1a, f1b, f2a, f2b}, 36'hF);
    rst_n = 1'b1;
    repeat (3) @(posedge clk_b);
    #1;
    check("R1 flags after reset", {32'd0, f1a, f1b, f2a, f2b}, 36'hF);
    mbx_a = 1; mbx_b = 1;
    #1;
    check("R1 mail2 zero", rd_a, '0);
    check("R1 mail1 zero", rd_b, '0);
    mbx_a = 0; mbx_b = 0;

    for (int i = 0; i < NV; i++) op(TBL[i], i);

    // R2 and R7: exact edges after a write
    @(negedge clk_a);
    cs_a = 1; en_a = 1; wr_a = 1; mbx_a = 1; wd_a = D6;
    @(posedge clk_a); #1;
    cs_a = 0; en_a = 0; wr_a = 0; mbx_a = 0;
    check("R2 writer flag low after edge", {35'd0, f1a}, 36'd0);
    @(posedge clk_b); #1;
    check("R7 rx view after first edge", {35'd0, f1b}, 36'd1);
    @(posedge clk_b); #1;
    check("R7 rx view after second edge", {35'd0, f1b}, 36'd0);

    // R6 and R11: ack timing with a write on the completing edge
    @(negedge clk_b);
    cs_b = 1; en_b = 1; wr_b = 0; mbx_b = 1;
    @(posedge clk_b); #1;
    check("R6 rx view high after read", {35'd0, f1b}, 36'd1);
    @(posedge clk_a); #1;
    cs_b = 0; en_b = 0; mbx_b = 0;
    check("R6 writer flag low after first edge", {35'd0, f1a}, 36'd0);
    cs_a = 1; en_a = 1; wr_a = 1; mbx_a = 1; wd_a = D7;
    @(posedge clk_a); #1;
    cs_a = 0; en_a = 0; wr_a = 0; mbx_a = 0;
    check("R6 writer flag high after second edge", {35'd0, f1a}, 36'd1);
    repeat (4) @(posedge clk_b); #1;
    check("R11 colliding write dropped flag", {35'd0, f1b}, 36'd1);
    read_b_mail("R11 colliding write dropped data", D6);

    // R10: read on empty view, then a write
    read_b_mail("R10 empty read data", D6);
    write_a_mail(D8);
    repeat (6) @(posedge clk_b); #1;
    check("R10 writer flag kept", {35'd0, f1a}, 36'd0);
    check("R10 rx flag kept", {35'd0, f1b}, 36'd0);
    read_b_mail("R10 new data", D8);

    repeat (6) @(posedge clk_b);
    finish_run();
  end
endmodule